// File: doc/BRIEF.md
# Serial Audio Port Register Bank

This block is the software-facing register file of a serial audio port. It holds a control word, a status word, a data word and a fixed version word behind a simple synchronous bus: an address, a write strobe, write data, and read data that follows the address combinationally. Every writable register has three extra addresses next to it. A write to one of them sets, clears or inverts only the bits given as ones, so software never needs a read-modify-write sequence.

The control word goes straight to the audio core. The status word combines live levels from the core (busy, DMA request, service request) with two sticky error flags that the core raises with one-cycle event pulses. The block merges the flags with their enables into a single interrupt line. A soft-reset bit in the control word holds the rest of the bank at its defaults. A clock-gate bit must be cleared before the port runs.

A three-state machine follows the control word and tells the core when it may run. In state GATED (the reset state) the clock gate is set. In LIVE the gate is clear. SOFTRST is held while soft reset is set. The transitions are GATED→LIVE when the gate clears, LIVE→GATED when it is set, GATED/LIVE→SOFTRST when soft reset is set, and SOFTRST→GATED or SOFTRST→LIVE when soft reset clears, picked by the gate bit. `port_en` is high only in LIVE.

Top module: `aport_regbank`

## Requirements
- R1: After reset the control word reads 0x4000_0000 (only the clock gate, bit 30, set). Data reads 0, both sticky flags are clear, `irq` is 0 and `port_en` is 0.
- R2: Address offset bits [3:2] select the write operation: 0 plain write, 1 set, 2 clear, 3 invert. A plain write to control (0x00) or data (0x20) loads the word. Control bits 23:21 are reserved: they always read 0 and ignore writes. A read at any of a register's four addresses returns that register.
- R3: A write to base+0x4 ORs the written mask into the register.
- R4: A write to base+0x8 clears the bits that are 1 in the written mask.
- R5: A write to base+0xC inverts the bits that are 1 in the written mask.
- R6: Status (0x10) reads bit 31 = 1 (present), bit 16 = DMA request, bit 4 = service request, bit 0 = busy, bit 6 = sticky underflow and bit 5 = sticky overflow. All other bits read 0. A one-cycle event pulse sets a sticky flag. Only bits 6:5 respond to status writes through all four aliases, so writing ones to 0x18 clears them.
- R7: A sticky flag whose event pulse arrives in the same cycle as a clear write to it ends up set.
- R8: The version word at 0x30 reads {major[31:24], minor[23:16], step[15:0]} (default 0x0102_0003). Writes to it have no effect.
- R9: Every other offset, including any address with bits [1:0] nonzero and 0x34 to 0x3C, reads 0. Writes there change nothing.
- R10: While control bit 31 (soft reset) is 1, every other control bit reads its reset value. From the next cycle the data word is held at 0 and the sticky flags are held clear; events are ignored and data writes are lost.
- R11: `irq` = ((underflow OR overflow) AND control bit 25) OR (service request AND control bit 24).
- R12: `port_en` rises one cycle after the control word shows both the gate (bit 30) and soft reset (bit 31) clear. It falls one cycle after either is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data or bit mask |
| rd_data | output | 32 | Read data for bus_addr |
| cfg_ctrl | output | 32 | Control word to the audio core |
| cfg_data | output | 32 | Data word to the audio core |
| port_en | output | 1 | Port may run (state LIVE) |
| core_busy | input | 1 | Core busy level |
| core_dma_req | input | 1 | Core DMA request level |
| core_svc_req | input | 1 | Core FIFO service request level |
| core_unf_evt | input | 1 | Underflow event pulse |
| core_ovf_evt | input | 1 | Overflow event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The control and data words are swept through all four operations with six masks: all zeros, all ones, two alternating patterns and two sparse ones. This separates set from invert from clear and shows that reserved control bits stay at zero. All eight busy/DMA/service combinations check the status bit layout. All 32 pairings of the two interrupt enables with the three flags check the interrupt equation term by term. Every byte address from 0x00 to 0xFF is read to find decode holes. Dedicated sequences cover event-versus-clear collisions, soft-reset holding and each state-machine transition.

// File: rtl/aport_regs_pkg.sv
package aport_regs_pkg;

    localparam int REG_W = 32;

    // block index = offset[ADDR_W-1:4]
    localparam int BLK_CTRL = 0;
    localparam int BLK_STAT = 1;
    localparam int BLK_DATA = 2;
    localparam int BLK_VER  = 3;

    // control fields
    localparam int C_SOFTRST = 31;
    localparam int C_GATE    = 30;
    localparam int C_ERR_IE  = 25;
    localparam int C_SVC_IE  = 24;

    // status fields
    localparam int S_PRESENT = 31;
    localparam int S_DMA     = 16;
    localparam int S_UNF     = 6;
    localparam int S_OVF     = 5;
    localparam int S_SVC     = 4;
    localparam int S_BUSY    = 0;

    localparam logic [REG_W-1:0] CTRL_RST   = 32'h4000_0000;
    localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFF1F_FFFF;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_STAT = 3'd2,
        SEL_DATA = 3'd3,
        SEL_VER  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        PS_GATED   = 2'd0,
        PS_LIVE    = 2'd1,
        PS_SOFTRST = 2'd2
    } port_state_e;

endpackage

// File: rtl/aport_addr_dec.sv
module aport_addr_dec
    import aport_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output alias_op_e         op
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       sub;
    logic             aligned;

    assign blk     = addr[ADDR_W-1:4];
    assign sub     = addr[3:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        op  = alias_op_e'(sub);
        sel = SEL_NONE;
        if (aligned) begin
            if (blk == BLK_W'(BLK_CTRL))
                sel = SEL_CTRL;
            else if (blk == BLK_W'(BLK_STAT))
                sel = SEL_STAT;
            else if (blk == BLK_W'(BLK_DATA))
                sel = SEL_DATA;
            else if (blk == BLK_W'(BLK_VER) && sub == 2'b00)
                sel = SEL_VER;
        end
    end
endmodule

// File: rtl/aport_alias_reg.sv
module aport_alias_reg
    import aport_regs_pkg::*;
#(
    parameter int             W         = 32,
    parameter logic [W-1:0]   RST       = '0,
    parameter logic [W-1:0]   WMASK     = '1,
    parameter bit             SELF_HOLD = 1'b0,
    parameter int             SELF_BIT  = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic         hold,
    output logic [W-1:0] q
);
    logic [W-1:0] op_res;
    logic [W-1:0] base_nxt;
    logic [W-1:0] fin_nxt;

    always_comb begin
        unique case (op)
            OP_WRITE: op_res = wdata;
            OP_SET:   op_res = q | wdata;
            OP_CLR:   op_res = q & ~wdata;
            OP_TOG:   op_res = q ^ wdata;
            default:  op_res = q;
        endcase
    end

    always_comb begin
        base_nxt = q;
        if (wr_en)
            base_nxt = op_res & WMASK;
        if (hold)
            base_nxt = RST;
    end

    generate
        if (SELF_HOLD) begin : g_self
            // the register's own hold bit forces every other field to reset
            always_comb begin
                fin_nxt = base_nxt;
                if (base_nxt[SELF_BIT])
                    fin_nxt = RST | (W'(1) << SELF_BIT);
            end
        end else begin : g_plain
            assign fin_nxt = base_nxt;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST;
        else
            q <= fin_nxt;
    end
endmodule

// File: rtl/aport_stat_reg.sv
module aport_stat_reg
    import aport_regs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  alias_op_e op,
    input  logic      wr_unf,
    input  logic      wr_ovf,
    input  logic      hold,
    input  logic      unf_evt,
    input  logic      ovf_evt,
    input  logic      err_ie,
    input  logic      svc_ie,
    input  logic      svc_lvl,
    output logic      unf_q,
    output logic      ovf_q,
    output logic      irq
);
    logic [1:0] cur;
    logic [1:0] wmask;
    logic [1:0] sw_nxt;
    logic [1:0] nxt;

    assign cur   = {unf_q, ovf_q};
    assign wmask = {wr_unf, wr_ovf};

    always_comb begin
        sw_nxt = cur;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: sw_nxt = wmask;
                OP_SET:   sw_nxt = cur | wmask;
                OP_CLR:   sw_nxt = cur & ~wmask;
                OP_TOG:   sw_nxt = cur ^ wmask;
                default:  sw_nxt = cur;
            endcase
        end
        // a hardware event wins over a software clear in the same cycle
        nxt = sw_nxt | {unf_evt, ovf_evt};
        if (hold)
            nxt = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unf_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            unf_q <= nxt[1];
            ovf_q <= nxt[0];
        end
    end

    assign irq = ((unf_q | ovf_q) & err_ie) | (svc_lvl & svc_ie);
endmodule

// File: rtl/aport_port_fsm.sv
module aport_port_fsm
    import aport_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic gate,
    output logic port_en
);
    port_state_e state;
    port_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_GATED: begin
                if (soft_rst)   nxt = PS_SOFTRST;
                else if (!gate) nxt = PS_LIVE;
            end
            PS_LIVE: begin
                if (soft_rst)  nxt = PS_SOFTRST;
                else if (gate) nxt = PS_GATED;
            end
            PS_SOFTRST: begin
                if (!soft_rst) nxt = gate ? PS_GATED : PS_LIVE;
            end
            default: nxt = PS_GATED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PS_GATED;
        else
            state <= nxt;
    end

    always_comb begin
        port_en = (state == PS_LIVE);
    end
endmodule

// File: rtl/aport_regbank.sv
module aport_regbank
    import aport_regs_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h02,
    parameter logic [15:0] VER_STEP  = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic [31:0]       cfg_ctrl,
    output logic [31:0]       cfg_data,
    output logic              port_en,
    input  logic              core_busy,
    input  logic              core_dma_req,
    input  logic              core_svc_req,
    input  logic              core_unf_evt,
    input  logic              core_ovf_evt,
    output logic              irq
);
    localparam logic [REG_W-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, VER_STEP};

    reg_sel_e    sel;
    alias_op_e   op;
    logic        soft_q;
    logic        stat_unf;
    logic        stat_ovf;
    logic [31:0] stat_word;

    aport_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .op   (op)
    );

    aport_alias_reg #(
        .W         (REG_W),
        .RST       (CTRL_RST),
        .WMASK     (CTRL_WMASK),
        .SELF_HOLD (1'b1),
        .SELF_BIT  (C_SOFTRST)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && sel == SEL_CTRL),
        .op    (op),
        .wdata (bus_wdata),
        .hold  (1'b0),
        .q     (cfg_ctrl)
    );

    assign soft_q = cfg_ctrl[C_SOFTRST];

    aport_alias_reg #(
        .W         (REG_W),
        .RST       ('0),
        .WMASK     ('1),
        .SELF_HOLD (1'b0),
        .SELF_BIT  (0)
    ) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && sel == SEL_DATA),
        .op    (op),
        .wdata (bus_wdata),
        .hold  (soft_q),
        .q     (cfg_data)
    );

    aport_stat_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel == SEL_STAT),
        .op      (op),
        .wr_unf  (bus_wdata[S_UNF]),
        .wr_ovf  (bus_wdata[S_OVF]),
        .hold    (soft_q),
        .unf_evt (core_unf_evt),
        .ovf_evt (core_ovf_evt),
        .err_ie  (cfg_ctrl[C_ERR_IE]),
        .svc_ie  (cfg_ctrl[C_SVC_IE]),
        .svc_lvl (core_svc_req),
        .unf_q   (stat_unf),
        .ovf_q   (stat_ovf),
        .irq     (irq)
    );

    aport_port_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_q),
        .gate     (cfg_ctrl[C_GATE]),
        .port_en  (port_en)
    );

    always_comb begin
        stat_word            = '0;
        stat_word[S_PRESENT] = 1'b1;
        stat_word[S_DMA]     = core_dma_req;
        stat_word[S_UNF]     = stat_unf;
        stat_word[S_OVF]     = stat_ovf;
        stat_word[S_SVC]     = core_svc_req;
        stat_word[S_BUSY]    = core_busy;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_data = cfg_ctrl;
            SEL_STAT: rd_data = stat_word;
            SEL_DATA: rd_data = cfg_data;
            SEL_VER:  rd_data = VER_WORD;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/aport_regbank_chk.sv
module aport_regbank_chk #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  VER_MAJOR = 8'h01,
    parameter logic [7:0]  VER_MINOR = 8'h02,
    parameter logic [15:0] VER_STEP  = 16'h0003
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       rd_data,
    input logic [31:0]       cfg_ctrl,
    input logic [31:0]       cfg_data,
    input logic              port_en,
    input logic              core_unf_evt,
    input logic              stat_unf,
    input logic              irq
);
    // R10
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl[31] |-> cfg_ctrl[30:0] == 31'h4000_0000);

    // R10
    soft_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl[31] |=> cfg_data == 32'h0);

    // R8
    ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_W'(8'h30) |-> rd_data == {VER_MAJOR, VER_MINOR, VER_STEP});

    // R9
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1:0] != 2'b00 |-> rd_data == 32'h0);

    // R2
    rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl[23:21] == 3'b000);

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ctrl[25] && !cfg_ctrl[24]) |-> !irq);

    // R12
    port_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> $past(!cfg_ctrl[31] && !cfg_ctrl[30]));

    // R7
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_unf_evt && !cfg_ctrl[31]) |=> stat_unf);
endmodule

bind aport_regbank aport_regbank_chk #(
    .ADDR_W    (ADDR_W),
    .VER_MAJOR (VER_MAJOR),
    .VER_MINOR (VER_MINOR),
    .VER_STEP  (VER_STEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .rd_data      (rd_data),
    .cfg_ctrl     (cfg_ctrl),
    .cfg_data     (cfg_data),
    .port_en      (port_en),
    .core_unf_evt (core_unf_evt),
    .stat_unf     (stat_unf),
    .irq          (irq)
);

// File: tb/tb_aport_regbank.sv
module tb_aport_regbank;
    localparam int CLK_P = 10;
    localparam logic [31:0] VER = 32'h0102_0003;
    localparam logic [31:0] WMSK = 32'hFF1F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data, cfg_ctrl, cfg_data;
    logic        port_en, irq;
    logic        core_busy = 0, core_dma_req = 0, core_svc_req = 0;
    logic        core_unf_evt = 0, core_ovf_evt = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] ctrl_m = 32'h4000_0000;
    logic [31:0] data_m = '0;
    logic        unf_m = 0, ovf_m = 0;

    always #(CLK_P/2) clk = ~clk;

    aport_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .cfg_ctrl(cfg_ctrl),
        .cfg_data(cfg_data), .port_en(port_en), .core_busy(core_busy),
        .core_dma_req(core_dma_req), .core_svc_req(core_svc_req),
        .core_unf_evt(core_unf_evt), .core_ovf_evt(core_ovf_evt), .irq(irq)
    );

    function automatic logic [31:0] alias_op(input int op, input logic [31:0] cur, input logic [31:0] w);
        case (op)
            0: return w;
            1: return cur | w;
            2: return cur & ~w;
            default: return cur ^ w;
        endcase
    endfunction

    function automatic logic [31:0] stat_exp();
        return {1'b1, 14'b0, core_dma_req, 9'b0, unf_m, ovf_m, core_svc_req, 3'b0, core_busy};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] w);
        @(negedge clk);
        bus_addr = a; bus_wdata = w; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rd_data;
    endtask

    // model update for a write, following the requirements
    task automatic model_wr(input logic [7:0] a, input logic [31:0] w);
        int op;
        logic [31:0] t;
        op = int'(a[3:2]);
        if (a[1:0] != 2'b00) return;
        if (a[7:4] == 4'h0) begin
            t = alias_op(op, ctrl_m, w) & WMSK;
            if (t[31]) t = 32'hC000_0000;
            ctrl_m = t;
        end else if (a[7:4] == 4'h1) begin
            t = alias_op(op, {25'b0, unf_m, ovf_m, 5'b0}, w);
            unf_m = t[6]; ovf_m = t[5];
        end else if (a[7:4] == 4'h2) begin
            if (!ctrl_m[31]) data_m = alias_op(op, data_m, w);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] w);
        bus_wr(a, w);
        model_wr(a, w);
    endtask

    task automatic pulse_evt(input logic u, input logic o);
        @(negedge clk);
        core_unf_evt = u; core_ovf_evt = o;
        @(negedge clk);
        core_unf_evt = 0; core_ovf_evt = 0;
        if (!ctrl_m[31]) begin unf_m |= u; ovf_m |= o; end
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_A5A5;
        pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h00FF_00F0; pats[5] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(8'h00, d); check("R1 ctrl", d, 32'h4000_0000);
        bus_rd(8'h20, d); check("R1 data", d, 32'h0);
        bus_rd(8'h10, d); check("R1 status", d, 32'h8000_0000);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 port_en", {31'b0, port_en}, 32'h0);

        // R12 state machine transitions
        wr(8'h08, 32'h4000_0000);
        check("R12 no early enable", {31'b0, port_en}, 32'h0);
        @(negedge clk);
        check("R12 GATED->LIVE", {31'b0, port_en}, 32'h1);
        wr(8'h04, 32'h8000_0000);
        @(negedge clk);
        check("R12 LIVE->SOFTRST", {31'b0, port_en}, 32'h0);
        wr(8'h00, 32'h4000_0000);
        @(negedge clk);
        check("R12 SOFTRST->GATED", {31'b0, port_en}, 32'h0);
        wr(8'h0C, 32'h4000_0000);
        @(negedge clk);
        check("R12 GATED->LIVE by toggle", {31'b0, port_en}, 32'h1);
        wr(8'h04, 32'h4000_0000);
        @(negedge clk);
        check("R12 LIVE->GATED", {31'b0, port_en}, 32'h0);
        wr(8'h04, 32'h8000_0000);
        wr(8'h00, 32'h0);
        @(negedge clk);
        check("R12 SOFTRST->LIVE", {31'b0, port_en}, 32'h1);

        // R2 R3 R4 R5 sweep: every op x masks on control and data
        for (int r = 0; r < 2; r++) begin
            for (int op = 0; op < 4; op++) begin
                for (int p = 0; p < 6; p++) begin
                    logic [7:0] a;
                    logic [31:0] w;
                    a = (r == 0) ? 8'h00 : 8'h20;
                    a = a | 8'(op << 2);
                    w = (r == 0) ? (pats[p] & 32'h7FFF_FFFF) : pats[p];
                    wr(a, w);
                    bus_rd(a, d);
                    if (op == 0)      check("R2 plain write", d, (r == 0) ? ctrl_m : data_m);
                    else if (op == 1) check("R3 set alias", d, (r == 0) ? ctrl_m : data_m);
                    else if (op == 2) check("R4 clear alias", d, (r == 0) ? ctrl_m : data_m);
                    else              check("R5 toggle alias", d, (r == 0) ? ctrl_m : data_m);
                end
            end
        end
        bus_rd(8'h00, d); check("R2 reserved ctrl bits", {29'b0, d[23:21]}, 32'h0);

        // R6 status layout, all live-input combinations
        wr(8'h00, 32'h0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            core_busy = k[0]; core_dma_req = k[1]; core_svc_req = k[2];
            bus_rd(8'h10, d); check("R6 status layout", d, stat_exp());
        end
        core_busy = 0; core_dma_req = 0; core_svc_req = 0;

        // R6 sticky flags and clear alias
        pulse_evt(1, 0);
        bus_rd(8'h10, d); check("R6 underflow sticky", d, stat_exp());
        pulse_evt(0, 1);
        bus_rd(8'h10, d); check("R6 overflow sticky", d, stat_exp());
        wr(8'h18, 32'h0000_0040);
        bus_rd(8'h10, d); check("R6 clear underflow", d, stat_exp());
        wr(8'h18, 32'hFFFF_FFFF);
        bus_rd(8'h10, d); check("R6 clear all", d, 32'h8000_0000);
        wr(8'h14, 32'hFFFF_FFFF);
        bus_rd(8'h10, d); check("R6 set alias bits 6:5 only", d, 32'h8000_0060);
        wr(8'h1C, 32'h0000_0020);
        bus_rd(8'h10, d); check("R6 toggle overflow", d, 32'h8000_0040);
        wr(8'h10, 32'h0);
        bus_rd(8'h10, d); check("R6 plain write clears", d, 32'h8000_0000);

        // R7 event beats clear in the same cycle
        pulse_evt(1, 1);
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'h60; bus_we = 1; core_unf_evt = 1;
        @(negedge clk);
        bus_we = 0; core_unf_evt = 0;
        unf_m = 1; ovf_m = 0;
        bus_rd(8'h10, d); check("R7 event wins over clear", d, 32'h8000_0040);

        // R11 interrupt, all enable x flag combinations
        for (int en = 0; en < 4; en++) begin
            for (int f = 0; f < 8; f++) begin
                logic e;
                wr(8'h00, {6'b0, en[1:0], 24'h0});
                wr(8'h18, 32'h60);
                pulse_evt(f[2], f[1]);
                core_svc_req = f[0];
                #1;
                e = ((f[2] | f[1]) & en[1]) | (f[0] & en[0]);
                check("R11 irq", {31'b0, irq}, {31'b0, e});
            end
        end
        core_svc_req = 0;

        // R10 soft reset
        wr(8'h00, 32'h0300_00F0);
        wr(8'h20, 32'hDEAD_BEEF);
        pulse_evt(1, 1);
        wr(8'h04, 32'h8000_0000);
        bus_rd(8'h00, d); check("R10 ctrl forced", d, 32'hC000_0000);
        @(negedge clk);
        data_m = 0; unf_m = 0; ovf_m = 0;
        bus_rd(8'h20, d); check("R10 data held", d, 32'h0);
        bus_rd(8'h10, d); check("R10 flags held", d, 32'h8000_0000);
        pulse_evt(1, 0);
        bus_rd(8'h10, d); check("R10 event ignored", d, 32'h8000_0000);
        wr(8'h20, 32'h1111_2222);
        bus_rd(8'h20, d); check("R10 data write lost", d, 32'h0);
        wr(8'h08, 32'h0000_0010);
        bus_rd(8'h00, d); check("R10 other fields ignored", d, 32'hC000_0000);
        wr(8'h00, 32'h0000_0010);
        bus_rd(8'h00, d); check("R10 release", d, 32'h0000_0010);

        // R8 version
        bus_rd(8'h30, d); check("R8 version", d, VER);
        wr(8'h30, 32'hFFFF_FFFF);
        bus_rd(8'h30, d); check("R8 version ignores write", d, VER);

        // R9 full address sweep
        wr(8'h20, 32'hCAFE_F00D);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] ad;
            logic [31:0] e;
            ad = 8'(a);
            e = 32'h0;
            if (ad[1:0] == 2'b00) begin
                if (ad[7:4] == 4'h0) e = ctrl_m;
                else if (ad[7:4] == 4'h1) e = stat_exp();
                else if (ad[7:4] == 4'h2) e = data_m;
                else if (ad == 8'h30) e = VER;
            end
            bus_rd(ad, d);
            if (d !== e) check("R9 address map", d, e);
            else n_chk++;
        end
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h42, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        bus_rd(8'h00, d); check("R9 ctrl untouched", d, ctrl_m);
        bus_rd(8'h20, d); check("R9 data untouched", d, data_m);
        bus_rd(8'h10, d); check("R9 status untouched", d, stat_exp());

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule